// File: doc/BRIEF.md
# Sixteen-Bit Capture/Compare Timer

This block is a 16-bit up-counter for a microcontroller peripheral set. It advances on one of several count sources chosen by software: every system clock, a tap of a free-running prescaler, or edges on an external pin. Edges on the external pin are sampled through a two-stage synchronizer. Two compare channels watch the counter. One input-capture channel copies the counter when a selected edge arrives on a capture pin. That pin can go through an optional four-sample noise filter.

Four events set sticky bits in one flag register. These are overflow, compare A, compare B and capture. A mask register with one enable per event turns each flag into its own interrupt line. Software reaches every register through a single-cycle register bus. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `cc_timer16`

## Requirements
- R1: After reset every register reads 0, including the counter, both compare values, the capture value, control, flags and mask, and every interrupt line is low.
- R2: A bus write to address 0 loads the counter at that clock edge. That cycle gives no increment and raises no overflow or compare event. Counting continues from the loaded value on the next count opportunity.
- R3: With clock-select code 0 (control bits [2:0]) the counter holds its value.
- R4: With clock-select code 1 the counter advances by one on every clock. When it advances from 0xFFFF to 0x0000, flag bit 0 (overflow) is set.
- R5: Clock-select codes 2, 3, 4 and 5 count once every 8, 64, 256 and 1024 clocks. A count occurs in a cycle where the low 3, 6, 8 or 10 bits of a 10-bit prescaler are all ones. The prescaler starts at 0 at reset and increments every clock.
- R6: Clock-select code 6 counts rising edges and code 7 counts falling edges of the external clock pin. The pin passes through two flip-flops, and each edge is counted at the third clock edge after the pin changes. Pin levels held for at least one clock are never missed.
- R7: Compare value A (address 1) and compare value B (address 2) set flag bit 1 and flag bit 2. A flag is set when a count occurs while the counter equals that compare value. A counter that is stopped or being written at that value sets nothing.
- R8: With control bit 3 set, a count that occurs while the counter equals compare value A loads 0 instead of incrementing. Such a clear never sets the overflow flag.
- R9: Flags (address 5) are sticky. Writing a 1 to a flag bit clears it, and writing a 0 leaves it alone. A set in the same cycle as a clear leaves the flag set.
- R10: On a capture-pin edge of the polarity chosen by control bit 4 (1 rising, 0 falling), the capture register (address 3) receives the counter value and flag bit 3 is set. With the filter off, the counter value taken is the one present in the second cycle after the pin change. Edges of the other polarity have no effect.
- R11: With control bit 5 set, a capture-pin level is accepted only after four equal consecutive synchronized samples. This adds four cycles of latency, and pulses shorter than four cycles cause no capture.
- R12: Interrupt line i (irq bit i) is high exactly when flag bit i and mask bit i (address 6) are both set.
- R13: The bus map is: 0 counter, 1 compare A, 2 compare B, 3 capture, 4 control, 5 flags, 6 mask, 7 reads 0. The capture register is read-only, so a write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| ext_clk_i | input | 1 | External count pin |
| cap_pin_i | input | 1 | Capture trigger pin |
| irq_o | output | 4 | Masked event requests: overflow, compare A, compare B, capture |

## Verification
The bench drives a load of 0xFFFA and counts through the wrap. A design that also incremented on the load cycle would land one count ahead and flag the overflow a cycle early. It times a flag clear to land on the same edge as a compare B match, where a design that gave priority to the clear would lose the event. It checks clear-on-compare with a compare value of 3, where an off-by-one design shows a period of five or a spurious overflow. It sends external edges at one clock per level and capture glitches three cycles long, which catch a synchronizer that drops counts or a filter that accepts short pulses.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

    localparam int NUM_EVT = 4;
    localparam int CTRL_W  = 6;

    localparam int EV_OVF  = 0;
    localparam int EV_CMPA = 1;
    localparam int EV_CMPB = 2;
    localparam int EV_CAPT = 3;

    localparam logic [2:0] A_COUNT = 3'd0;
    localparam logic [2:0] A_CMPA  = 3'd1;
    localparam logic [2:0] A_CMPB  = 3'd2;
    localparam logic [2:0] A_CAPT  = 3'd3;
    localparam logic [2:0] A_CTRL  = 3'd4;
    localparam logic [2:0] A_FLAGS = 3'd5;
    localparam logic [2:0] A_MASK  = 3'd6;

    typedef enum logic [2:0] {
        CS_STOP     = 3'd0,
        CS_SYS      = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_RISE = 3'd6,
        CS_EXT_FALL = 3'd7
    } clk_sel_e;

    typedef struct packed {
        logic     nc_en;     // bit 5
        logic     cap_rise;  // bit 4
        logic     ctc;       // bit 3
        clk_sel_e sel;       // bits 2:0
    } ctrl_t;

endpackage

// File: rtl/tmr_clk_select.sv
module tmr_clk_select
    import cc_timer_pkg::*;
#(
    parameter int PSC_W = 10
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  clk_sel_e sel_i,
    input  logic     ext_i,
    output logic     tick_o
);
    localparam int NUM_TAP = 4;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             e1;
        logic             e2;
        logic             e3;
    } cs_state_t;

    cs_state_t st_d, st_q;
    logic [NUM_TAP-1:0] tap_hit;

    // Tap widths for divide by 8, 64, 256, 1024.
    for (genvar g = 0; g < NUM_TAP; g++) begin : g_tap
        localparam int TW = (g == 0) ? 3 : (g == 1) ? 6 : (g == 2) ? 8 : 10;
        assign tap_hit[g] = &st_q.psc[TW-1:0];
    end

    always_comb begin
        st_d     = st_q;
        st_d.psc = st_q.psc + PSC_W'(1);
        st_d.e1  = ext_i;
        st_d.e2  = st_q.e1;
        st_d.e3  = st_q.e2;
        unique case (sel_i)
            CS_STOP:     tick_o = 1'b0;
            CS_SYS:      tick_o = 1'b1;
            CS_DIV8:     tick_o = tap_hit[0];
            CS_DIV64:    tick_o = tap_hit[1];
            CS_DIV256:   tick_o = tap_hit[2];
            CS_DIV1024:  tick_o = tap_hit[3];
            CS_EXT_RISE: tick_o = st_q.e2 & ~st_q.e3;
            CS_EXT_FALL: tick_o = ~st_q.e2 & st_q.e3;
            default:     tick_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tmr_capture_in.sv
module tmr_capture_in #(
    parameter int NF_DEPTH = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic rise_sel_i,
    input  logic nc_en_i,
    output logic evt_o
);
    typedef struct packed {
        logic                s1;
        logic                s2;
        logic [NF_DEPTH-1:0] hist;
        logic                lvl;
    } ci_state_t;

    ci_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.hist = {st_q.hist[NF_DEPTH-2:0], st_q.s2};
        if (nc_en_i) begin
            if (&st_q.hist)      st_d.lvl = 1'b1;
            else if (~|st_q.hist) st_d.lvl = 1'b0;
            else                  st_d.lvl = st_q.lvl;
        end else begin
            st_d.lvl = st_q.s2;
        end
        evt_o = (st_d.lvl != st_q.lvl) && (rise_sel_i ? st_d.lvl : ~st_d.lvl);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/cc_timer16.sv
module cc_timer16
    import cc_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PSC_W    = 10,
    parameter int NF_DEPTH = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    input  logic              ext_clk_i,
    input  logic              cap_pin_i,
    output logic [NUM_EVT-1:0] irq_o
);
    localparam int NUM_CMP = 2;

    typedef struct packed {
        logic [CNT_W-1:0]                count;
        logic [NUM_CMP-1:0][CNT_W-1:0]   cmp;
        logic [CNT_W-1:0]                capt;
        ctrl_t                           ctrl;
        logic [NUM_EVT-1:0]              flags;
        logic [NUM_EVT-1:0]              mask;
    } tm_state_t;

    tm_state_t st_d, st_q;

    logic               tick_w;
    logic               cap_evt_w;
    logic [NUM_CMP-1:0] cmp_hit;
    logic               wr_count;
    logic               ctc_clr;
    logic [NUM_EVT-1:0] ev_set;
    logic [NUM_EVT-1:0] ev_clr;
    logic [CNT_W-1:0]   count_w;
    logic [CNT_W-1:0]   cmpa_w;

    tmr_clk_select #(.PSC_W(PSC_W)) u_clk_sel (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (st_q.ctrl.sel),
        .ext_i  (ext_clk_i),
        .tick_o (tick_w)
    );

    tmr_capture_in #(.NF_DEPTH(NF_DEPTH)) u_cap_in (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (cap_pin_i),
        .rise_sel_i (st_q.ctrl.cap_rise),
        .nc_en_i    (st_q.ctrl.nc_en),
        .evt_o      (cap_evt_w)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        assign cmp_hit[g] = (st_q.count == st_q.cmp[g]);
    end

    assign count_w = st_q.count;
    assign cmpa_w  = st_q.cmp[0];

    always_comb begin
        st_d     = st_q;
        ev_set   = '0;
        wr_count = bus_wr_i && (bus_addr_i == A_COUNT);
        ctc_clr  = st_q.ctrl.ctc && cmp_hit[0];

        if (wr_count) begin
            st_d.count = bus_wdata_i;
        end else if (tick_w) begin
            if (ctc_clr) st_d.count = '0;
            else         st_d.count = st_q.count + CNT_W'(1);
            ev_set[EV_OVF] = (&st_q.count) && !ctc_clr;
            for (int i = 0; i < NUM_CMP; i++) ev_set[EV_CMPA+i] = cmp_hit[i];
        end

        if (cap_evt_w) begin
            st_d.capt       = st_q.count;
            ev_set[EV_CAPT] = 1'b1;
        end

        ev_clr = '0;
        if (bus_wr_i) begin
            unique case (bus_addr_i)
                A_CMPA:  st_d.cmp[0] = bus_wdata_i;
                A_CMPB:  st_d.cmp[1] = bus_wdata_i;
                A_CTRL:  st_d.ctrl   = ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
                A_FLAGS: ev_clr      = bus_wdata_i[NUM_EVT-1:0];
                A_MASK:  st_d.mask   = bus_wdata_i[NUM_EVT-1:0];
                default: ;
            endcase
        end
        st_d.flags = (st_q.flags & ~ev_clr) | ev_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        unique case (bus_addr_i)
            A_COUNT: bus_rdata_o = st_q.count;
            A_CMPA:  bus_rdata_o = st_q.cmp[0];
            A_CMPB:  bus_rdata_o = st_q.cmp[1];
            A_CAPT:  bus_rdata_o = st_q.capt;
            A_CTRL:  bus_rdata_o = CNT_W'(st_q.ctrl);
            A_FLAGS: bus_rdata_o = CNT_W'(st_q.flags);
            A_MASK:  bus_rdata_o = CNT_W'(st_q.mask);
            default: bus_rdata_o = '0;
        endcase
    end

    assign irq_o = st_q.flags & st_q.mask;

endmodule

// File: rtl/cc_timer16_checker.sv
module cc_timer16_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             bus_wr_i,
    input logic [2:0]       bus_addr_i,
    input logic [CNT_W-1:0] bus_wdata_i,
    input logic [CNT_W-1:0] count_i,
    input logic [CNT_W-1:0] cmpa_i,
    input logic [CNT_W-1:0] capt_i,
    input logic [3:0]       flags_i,
    input logic [2:0]       sel_i,
    input logic             ctc_i,
    input logic             tick_i,
    input logic             cap_evt_i
);
    logic       load_c;
    logic       ctc_hit;
    logic [3:0] clr_c;

    assign load_c  = bus_wr_i && (bus_addr_i == 3'd0);
    assign ctc_hit = ctc_i && (count_i == cmpa_i);
    assign clr_c   = (bus_wr_i && (bus_addr_i == 3'd5)) ? bus_wdata_i[3:0] : 4'h0;

    p_count_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_c |=> count_i == $past(bus_wdata_i));

    p_stopped_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == 3'd0 && !load_c) |=> $stable(count_i));

    p_sys_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == 3'd1 && !load_c && !ctc_hit) |=> count_i == $past(count_i) + CNT_W'(1));

    p_wrap_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_c && (&count_i) && !ctc_hit) |=> flags_i[0]);

    p_ctc_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_c && ctc_hit) |=> count_i == '0);

    p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_i != 4'h0) |=> ((($past(flags_i) & ~$past(clr_c)) & ~flags_i) == 4'h0));

    p_capture_copy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_evt_i |=> (capt_i == $past(count_i)) && flags_i[3]);

endmodule

bind cc_timer16 cc_timer16_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .count_i     (count_w),
    .cmpa_i      (cmpa_w),
    .capt_i      (st_q.capt),
    .flags_i     (st_q.flags),
    .sel_i       (st_q.ctrl.sel),
    .ctc_i       (st_q.ctrl.ctc),
    .tick_i      (tick_w),
    .cap_evt_i   (cap_evt_w)
);

// File: tb/cc_timer16_bench.sv
`timescale 1ns/1ps
module cc_timer16_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        ext = 1'b0;
    logic        cap = 1'b0;
    logic [3:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cc_timer16 u_cc_timer16 (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_clk_i(ext),
        .cap_pin_i(cap), .irq_o(irq)
    );

    // Behavioural reference model
    logic [15:0] m_cnt, m_cmpa, m_cmpb, m_cap, n_cnt, n_cap;
    logic [5:0]  m_ctrl;
    logic [3:0]  m_flags, m_mask, m_hist, ev, clr;
    int          m_psc;
    logic        m_e1, m_e2, m_e3, m_c1, m_c2, m_lvl, n_lvl, t;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmpa = 0; m_cmpb = 0; m_cap = 0; m_ctrl = 0;
            m_flags = 0; m_mask = 0; m_hist = 0; m_psc = 0;
            m_e1 = 0; m_e2 = 0; m_e3 = 0; m_c1 = 0; m_c2 = 0; m_lvl = 0;
        end else begin
            case (m_ctrl[2:0])
                3'd0: t = 0;
                3'd1: t = 1;
                3'd2: t = (m_psc % 8) == 7;
                3'd3: t = (m_psc % 64) == 63;
                3'd4: t = (m_psc % 256) == 255;
                3'd5: t = (m_psc % 1024) == 1023;
                3'd6: t = m_e2 && !m_e3;
                default: t = !m_e2 && m_e3;
            endcase
            ev = 0;
            n_cnt = m_cnt;
            if (wr && addr == 3'd0) n_cnt = wdata;
            else if (t) begin
                if (m_ctrl[3] && m_cnt == m_cmpa) n_cnt = 0;
                else begin
                    n_cnt = m_cnt + 16'd1;
                    if (m_cnt == 16'hFFFF) ev[0] = 1;
                end
                if (m_cnt == m_cmpa) ev[1] = 1;
                if (m_cnt == m_cmpb) ev[2] = 1;
            end
            if (m_ctrl[5]) n_lvl = (m_hist == 4'hF) ? 1'b1 : (m_hist == 4'h0) ? 1'b0 : m_lvl;
            else           n_lvl = m_c2;
            n_cap = m_cap;
            if (n_lvl != m_lvl && (m_ctrl[4] ? n_lvl : !n_lvl)) begin
                n_cap = m_cnt; ev[3] = 1;
            end
            clr = (wr && addr == 3'd5) ? wdata[3:0] : 4'h0;
            m_flags = (m_flags & ~clr) | ev;
            if (wr && addr == 3'd1) m_cmpa = wdata;
            if (wr && addr == 3'd2) m_cmpb = wdata;
            if (wr && addr == 3'd4) m_ctrl = wdata[5:0];
            if (wr && addr == 3'd6) m_mask = wdata[3:0];
            m_hist = {m_hist[2:0], m_c2};
            m_c2 = m_c1; m_c1 = cap;
            m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext;
            m_psc = (m_psc + 1) % 1024;
            m_lvl = n_lvl; m_cnt = n_cnt; m_cap = n_cap;
        end
    end

    function automatic logic [15:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt;
            3'd1: return m_cmpa;
            3'd2: return m_cmpb;
            3'd3: return m_cap;
            3'd4: return {10'd0, m_ctrl};
            3'd5: return {12'd0, m_flags};
            3'd6: return {12'd0, m_mask};
            default: return 16'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R12 irq, R13 read path)
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            check("R13 read", rdata, model_read(addr));
            check("R12 irq", {12'd0, irq}, {12'd0, m_flags & m_mask});
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset reg", v, 16'h0);
        end
        check("R1 irq low", {12'd0, irq}, 16'h0);
        // R3 stopped
        repeat (5) @(negedge clk);
        rd(3'd0, v); check("R3 stopped count", v, 16'h0);

        // R2/R4 load and wrap
        wr_reg(3'd4, 16'h0001);
        wr_reg(3'd5, 16'h000F);
        @(negedge clk); wr = 1; addr = 3'd0; wdata = 16'hFFFA;
        @(negedge clk); wr = 0; #1 check("R2 loaded no increment", rdata, 16'hFFFA);
        @(negedge clk); #1 check("R2 resumes", rdata, 16'hFFFB);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1 check("R4 step", rdata, 16'hFFFC + 16'(i));
        end
        @(negedge clk); #1 check("R4 wrap", rdata, 16'h0000);
        addr = 3'd5; #0.5 check("R4 overflow flag", rdata, 16'h0001);
        @(negedge clk); #1 check("R7 compare flags at 0", rdata, 16'h0007);
        wr_reg(3'd5, 16'h0001);
        rd(3'd5, v); check("R9 selective clear", v, 16'h0006);

        // R9 set wins over clear
        wr_reg(3'd2, 16'h0101);
        wr_reg(3'd5, 16'h000F);
        @(negedge clk); wr = 1; addr = 3'd0; wdata = 16'h0100;
        @(negedge clk); wr = 0;
        @(negedge clk); wr = 1; addr = 3'd5; wdata = 16'h0004;
        @(negedge clk); wr = 0; #1 check("R9 set beats clear", rdata & 16'h4, 16'h0004);

        // R7 stopped at compare value sets nothing
        wr_reg(3'd4, 16'h0000);
        wr_reg(3'd0, 16'h0101);
        wr_reg(3'd5, 16'h000F);
        repeat (4) @(negedge clk);
        rd(3'd5, v); check("R7 stopped no match", v, 16'h0000);

        // R8 clear on compare A
        wr_reg(3'd1, 16'h0003);
        wr_reg(3'd4, 16'h0009);
        @(negedge clk); wr = 1; addr = 3'd0; wdata = 16'h0000;
        @(negedge clk); wr = 0; #1 check("R8 seq", rdata, 16'h0000);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1 check("R8 seq", rdata, (i < 3) ? 16'(i + 1) : 16'(i - 3));
        end
        rd(3'd5, v); check("R8 no overflow", v & 16'h1, 16'h0000);

        // R5 prescaled modes
        for (int m = 2; m <= 5; m++) begin
            wr_reg(3'd4, 16'(m));
            wr_reg(3'd0, 16'h0000);
            repeat (2200) @(negedge clk);
            rd(3'd0, v); check("R5 prescaled count", v, m_cnt);
            check("R5 nonzero", 16'(v != 0), 16'h1);
        end

        // R6 external rising
        wr_reg(3'd4, 16'h0006);
        wr_reg(3'd0, 16'h0000);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); ext = 1; repeat (2) @(negedge clk); ext = 0; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(3'd0, v); check("R6 rising count", v, 16'd10);
        wr_reg(3'd0, 16'h0000);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ext = 1; @(negedge clk); ext = 0;
        end
        repeat (4) @(negedge clk);
        rd(3'd0, v); check("R6 fast edges", v, 16'd8);
        wr_reg(3'd4, 16'h0007);
        wr_reg(3'd0, 16'h0000);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); ext = 1; repeat (3) @(negedge clk); ext = 0; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(3'd0, v); check("R6 falling count", v, 16'd6);

        // R10 capture rising then falling
        wr_reg(3'd4, 16'h0011);
        wr_reg(3'd5, 16'h000F);
        @(negedge clk); cap = 1;
        repeat (6) @(negedge clk);
        rd(3'd3, v); check("R10 rising capture", v, m_cap);
        check("R10 capture nonzero", 16'(v != 0), 16'h1);
        rd(3'd5, v); check("R10 capture flag", v & 16'h8, 16'h0008);
        wr_reg(3'd4, 16'h0001);
        wr_reg(3'd5, 16'h000F);
        rd(3'd3, v2);
        @(negedge clk); cap = 0;
        repeat (6) @(negedge clk);
        rd(3'd3, v); check("R10 falling capture", v, m_cap);
        check("R10 falling moved", 16'(v != v2), 16'h1);
        wr_reg(3'd5, 16'h000F);
        @(negedge clk); cap = 1;
        repeat (6) @(negedge clk);
        rd(3'd5, v); check("R10 wrong edge ignored", v & 16'h8, 16'h0000);
        @(negedge clk); cap = 0;
        repeat (6) @(negedge clk);

        // R11 noise cancel
        wr_reg(3'd4, 16'h0031);
        repeat (8) @(negedge clk);
        wr_reg(3'd5, 16'h000F);
        @(negedge clk); cap = 1; repeat (3) @(negedge clk); cap = 0;
        repeat (10) @(negedge clk);
        rd(3'd5, v); check("R11 glitch rejected", v & 16'h8, 16'h0000);
        @(negedge clk); cap = 1; repeat (8) @(negedge clk);
        rd(3'd5, v); check("R11 long pulse accepted", v & 16'h8, 16'h0008);
        rd(3'd3, v); check("R11 captured value", v, m_cap);

        // R12 mask gating
        wr_reg(3'd6, 16'h0008);
        @(negedge clk); #1 check("R12 masked irq", {12'd0, irq}, {12'd0, m_flags & 4'h8});
        wr_reg(3'd6, 16'h0000);
        @(negedge clk); #1 check("R12 all masked", {12'd0, irq}, 16'h0);

        // R13 capture read-only
        rd(3'd3, v2);
        wr_reg(3'd3, 16'hBEEF);
        rd(3'd3, v); check("R13 capture write ignored", v, v2);
        rd(3'd7, v); check("R13 unused address", v, 16'h0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule